// File: doc/BRIEF.md
# NAND Flash Block Erase Sequencer

This block sits on the host side of an 8-bit NAND flash bus and performs one block erase for each accepted request. A requester offers a block number on a valid/ready handshake. The sequencer then runs the whole erase exchange on the flash bus without further help. It strobes the erase-setup opcode, shifts out the row address over three address-latch cycles, and strobes the erase-confirm opcode. It then holds off while the device reports busy, reads the status byte, and returns a one-cycle completion pulse carrying a pass/fail verdict.

Every bus cycle is built from one write-enable (or read-enable) pulse. The pulse is low for a configurable number of clocks and high for the same number. The command-latch, address-latch and data lines stay unchanged across the whole pulse. The ready/busy line is resynchronised before use. A guard interval after the confirm opcode gives the device time to pull the line low. A poll-cycle limit turns a device that never becomes ready into a reported failure rather than a hang.

Top module: `nand_erase_seq`

## Requirements
- R1: During and straight after reset, req_ready is 1, nand_ce_n, nand_we_n and nand_re_n are 1, and nand_cle, nand_ale, nand_dq_oe, done, fail and timed_out are 0.
- R2: A request is accepted on a clock edge where req_valid and req_ready are both 1. req_ready then stays 0 until the cycle in which done pulses. A request presented while req_ready is 0 starts no bus activity and does not alter the block being erased.
- R3: The first bus cycle of an erase is a command cycle (nand_cle=1, nand_ale=0) carrying 0x60.
- R4: Exactly three address cycles (nand_ale=1, nand_cle=0) follow. With the row value equal to req_block shifted left by PG_W (default 5, so the in-block page bits are zero), the bytes are row[7:0], row[15:8] and row[23:16], in that order.
- R5: Right after the third address cycle comes exactly one command cycle carrying 0xD0, and no other write cycle lies between the address cycles and it.
- R6: Each write or read pulse holds its enable low for HALF_CYC clocks. nand_cle, nand_ale and nand_dq_out do not change on the clock where the enable returns high.
- R7: After the confirm opcode and a guard of GUARD_CYC clocks, the block waits for the synchronised nand_rb to be high. It then issues command 0x70 and one read pulse, and samples nand_dq_in during that pulse.
- R8: Completion is a done pulse exactly one clock wide. In that clock, fail equals bit 0 of the sampled status byte (1 means the erase failed), and timed_out is 0 for a completed status read.
- R9: If the synchronised nand_rb stays low for more than BUSY_LIMIT poll clocks, done pulses with fail=1 and timed_out=1, and no 0x70 command or read pulse is issued.
- R10: nand_cle and nand_ale are never 1 together, and nand_we_n and nand_re_n are never 0 together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Erase request offered |
| req_ready | output | 1 | Sequencer idle and able to accept |
| req_block | input | BLK_W | Block number to erase |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Erase failed or timed out, valid with done |
| timed_out | output | 1 | Busy wait exceeded its limit, valid with done |
| nand_ce_n | output | 1 | Chip enable, low during an erase |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write enable strobe, active low |
| nand_re_n | output | 1 | Read enable strobe, active low |
| nand_dq_out | output | 8 | Byte driven onto the flash data bus |
| nand_dq_oe | output | 1 | Output enable for nand_dq_out |
| nand_dq_in | input | 8 | Byte read from the flash data bus |
| nand_rb | input | 1 | Ready/busy from the device, low while busy |

## Verification
A wrong sequencer state shows on the bus within one strobe period: a missing, doubled or reordered opcode, or a stray address byte, appears in the latched-cycle log at the next write-enable rising edge. A fault in the busy wait or the status path appears at the done pulse. Such a fault gives a wrong fail or timed_out value, a status read after a timeout, or a done that never arrives or lasts two clocks. The address shifter is swept with walking-one and alternating block numbers so that a swapped or shifted byte is caught on the erase that carries that bit.

// File: rtl/nand_erase_pkg.sv
package nand_erase_pkg;

   // kind of a single flash bus cycle
   typedef enum logic [1:0] {
      BUS_CMD,
      BUS_ADDR,
      BUS_READ
   } bus_kind_e;

   // erase sequencer states, in issue order
   typedef enum logic [3:0] {
      ST_IDLE,
      ST_SETUP,
      ST_ADDR0,
      ST_ADDR1,
      ST_ADDR2,
      ST_CONFIRM,
      ST_WAIT,
      ST_STATUS,
      ST_READ
   } seq_state_e;

   localparam logic [7:0] OP_ERASE_SETUP  = 8'h60;
   localparam logic [7:0] OP_ERASE_GO     = 8'hD0;
   localparam logic [7:0] OP_READ_STATUS  = 8'h70;
   localparam int         ADDR_CYCLES     = 3;

endpackage

// File: rtl/nand_erase_strobe.sv
module nand_erase_strobe
   import nand_erase_pkg::*;
#(
   parameter int HALF_CYC = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      start,
   input  bus_kind_e kind,
   input  logic [7:0] wr_byte,
   input  logic [7:0] rd_bus,
   output logic      cle,
   output logic      ale,
   output logic      we_n,
   output logic      re_n,
   output logic [7:0] dq_out,
   output logic      dq_oe,
   output logic      fin,
   output logic [7:0] rd_byte
);

   localparam int CW = (HALF_CYC < 2) ? 1 : $clog2(HALF_CYC);

   if (HALF_CYC < 1) begin : g_bad_half
      $error("HALF_CYC must be at least 1");
   end

   typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_HIGH} phase_e;

   phase_e     phase;
   logic [CW-1:0] cnt;
   bus_kind_e  kind_q;
   logic [7:0] byte_q;
   logic [7:0] rd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase  <= PH_IDLE;
         cnt    <= '0;
         kind_q <= BUS_CMD;
         byte_q <= '0;
         rd_q   <= '0;
      end else begin
         case (phase)
            PH_IDLE: begin
               if (start) begin
                  phase  <= PH_LOW;
                  cnt    <= CW'(HALF_CYC - 1);
                  kind_q <= kind;
                  byte_q <= wr_byte;
               end
            end
            PH_LOW: begin
               if (cnt == '0) begin
                  if (kind_q == BUS_READ) rd_q <= rd_bus;
                  phase <= PH_HIGH;
                  cnt   <= CW'(HALF_CYC - 1);
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            PH_HIGH: begin
               if (cnt == '0) phase <= PH_IDLE;
               else           cnt   <= cnt - 1'b1;
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   always_comb begin
      cle    = (phase != PH_IDLE) && (kind_q == BUS_CMD);
      ale    = (phase != PH_IDLE) && (kind_q == BUS_ADDR);
      we_n   = !((phase == PH_LOW) && (kind_q != BUS_READ));
      re_n   = !((phase == PH_LOW) && (kind_q == BUS_READ));
      dq_oe  = (phase != PH_IDLE) && (kind_q != BUS_READ);
      dq_out = byte_q;
      fin    = (phase == PH_HIGH) && (cnt == '0);
   end

   assign rd_byte = rd_q;

   // R10: latch enables exclusive, strobes exclusive
   p_cle_ale_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(cle && ale));
   p_we_re_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(!we_n && !re_n));
   // R6: data and latch enables held over the rising strobe edge
   p_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(we_n) |-> ($stable(dq_out) && $stable(cle) && $stable(ale)));
   // R6: a new cycle is requested only on an idle bus
   p_start_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> (phase == PH_IDLE));

endmodule

// File: rtl/nand_erase_busywait.sv
module nand_erase_busywait #(
   parameter int SYNC_STAGES = 2,
   parameter int GUARD_CYC   = 8,
   parameter int LIMIT       = 1000000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic rb,
   output logic done,
   output logic timed_out
);

   localparam int GW = (GUARD_CYC < 2) ? 1 : $clog2(GUARD_CYC);
   localparam int LW = $clog2(LIMIT + 1);

   if (GUARD_CYC < 1) begin : g_bad_guard
      $error("GUARD_CYC must be at least 1");
   end
   if (LIMIT < 1) begin : g_bad_limit
      $error("LIMIT must be at least 1");
   end

   logic rb_s;

   if (SYNC_STAGES == 0) begin : g_nosync
      assign rb_s = rb;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] sh;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sh <= '1;
         end else begin
            sh[0] <= rb;
            for (int k = 1; k < SYNC_STAGES; k++) sh[k] <= sh[k-1];
         end
      end
      assign rb_s = sh[SYNC_STAGES-1];
   end

   typedef enum logic [1:0] {W_IDLE, W_GUARD, W_POLL} wait_e;

   wait_e         st;
   logic [GW-1:0] gcnt;
   logic [LW-1:0] lcnt;
   logic          over;

   assign over      = (lcnt == LW'(LIMIT));
   assign done      = (st == W_POLL) && (rb_s || over);
   assign timed_out = (st == W_POLL) && !rb_s && over;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= W_IDLE;
         gcnt <= '0;
         lcnt <= '0;
      end else begin
         case (st)
            W_IDLE: begin
               if (start) begin
                  st   <= W_GUARD;
                  gcnt <= GW'(GUARD_CYC - 1);
               end
            end
            W_GUARD: begin
               if (gcnt == '0) begin
                  st   <= W_POLL;
                  lcnt <= '0;
               end else begin
                  gcnt <= gcnt - 1'b1;
               end
            end
            W_POLL: begin
               if (done) st   <= W_IDLE;
               else      lcnt <= lcnt + 1'b1;
            end
            default: st <= W_IDLE;
         endcase
      end
   end

   // R7: a wait is only started when none is running
   p_start_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> (st == W_IDLE));

endmodule

// File: rtl/nand_erase_seq.sv
module nand_erase_seq
   import nand_erase_pkg::*;
#(
   parameter int BLK_W       = 14,
   parameter int PG_W        = 5,
   parameter int HALF_CYC    = 2,
   parameter int GUARD_CYC   = 8,
   parameter int BUSY_LIMIT  = 1000000,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [BLK_W-1:0] req_block,
   output logic             done,
   output logic             fail,
   output logic             timed_out,
   output logic             nand_ce_n,
   output logic             nand_cle,
   output logic             nand_ale,
   output logic             nand_we_n,
   output logic             nand_re_n,
   output logic [7:0]       nand_dq_out,
   output logic             nand_dq_oe,
   input  logic [7:0]       nand_dq_in,
   input  logic             nand_rb
);

   localparam int RW = 8 * ADDR_CYCLES;

   if (BLK_W < 1 || BLK_W + PG_W > RW) begin : g_bad_row
      $error("block number plus page bits must fit the address cycles");
   end

   seq_state_e       state;
   logic             issued;
   logic [BLK_W-1:0] blk_q;
   logic             done_q, fail_q, to_q;

   logic [RW-1:0]    row_addr;
   logic [7:0]       abyte [ADDR_CYCLES];

   assign row_addr = RW'(blk_q) << PG_W;

   for (genvar i = 0; i < ADDR_CYCLES; i++) begin : g_abyte
      assign abyte[i] = row_addr[8*i +: 8];
   end

   // bus cycle request for the current state
   logic       on_bus;
   bus_kind_e  b_kind;
   logic [7:0] b_byte;
   seq_state_e b_next;

   always_comb begin
      on_bus = 1'b1;
      b_kind = BUS_CMD;
      b_byte = 8'h00;
      b_next = ST_IDLE;
      case (state)
         ST_SETUP:   begin b_byte = OP_ERASE_SETUP; b_next = ST_ADDR0; end
         ST_ADDR0:   begin b_kind = BUS_ADDR; b_byte = abyte[0]; b_next = ST_ADDR1; end
         ST_ADDR1:   begin b_kind = BUS_ADDR; b_byte = abyte[1]; b_next = ST_ADDR2; end
         ST_ADDR2:   begin b_kind = BUS_ADDR; b_byte = abyte[2]; b_next = ST_CONFIRM; end
         ST_CONFIRM: begin b_byte = OP_ERASE_GO; b_next = ST_WAIT; end
         ST_STATUS:  begin b_byte = OP_READ_STATUS; b_next = ST_READ; end
         ST_READ:    begin b_kind = BUS_READ; b_next = ST_IDLE; end
         default:    on_bus = 1'b0;
      endcase
   end

   logic       bus_start, bus_fin;
   logic [7:0] stat_byte;
   logic       bw_start, bw_done, bw_to;

   assign bus_start = on_bus && !issued;
   assign bw_start  = (state == ST_CONFIRM) && bus_fin;

   nand_erase_strobe #(.HALF_CYC(HALF_CYC)) u_strobe (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (bus_start),
      .kind    (b_kind),
      .wr_byte (b_byte),
      .rd_bus  (nand_dq_in),
      .cle     (nand_cle),
      .ale     (nand_ale),
      .we_n    (nand_we_n),
      .re_n    (nand_re_n),
      .dq_out  (nand_dq_out),
      .dq_oe   (nand_dq_oe),
      .fin     (bus_fin),
      .rd_byte (stat_byte)
   );

   nand_erase_busywait #(
      .SYNC_STAGES (SYNC_STAGES),
      .GUARD_CYC   (GUARD_CYC),
      .LIMIT       (BUSY_LIMIT)
   ) u_wait (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (bw_start),
      .rb        (nand_rb),
      .done      (bw_done),
      .timed_out (bw_to)
   );

   logic unused_stat;
   assign unused_stat = ^stat_byte[7:1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         issued <= 1'b0;
         blk_q  <= '0;
         done_q <= 1'b0;
         fail_q <= 1'b0;
         to_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         fail_q <= 1'b0;
         to_q   <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (req_valid) begin
                  blk_q  <= req_block;
                  state  <= ST_SETUP;
                  issued <= 1'b0;
               end
            end
            ST_WAIT: begin
               if (bw_done) begin
                  if (bw_to) begin
                     done_q <= 1'b1;
                     fail_q <= 1'b1;
                     to_q   <= 1'b1;
                     state  <= ST_IDLE;
                  end else begin
                     state  <= ST_STATUS;
                  end
               end
            end
            default: begin
               if (bus_start) issued <= 1'b1;
               if (bus_fin) begin
                  issued <= 1'b0;
                  state  <= b_next;
                  if (state == ST_READ) begin
                     done_q <= 1'b1;
                     fail_q <= stat_byte[0];
                  end
               end
            end
         endcase
      end
   end

   assign req_ready = (state == ST_IDLE);
   assign nand_ce_n = (state == ST_IDLE);
   assign done      = done_q;
   assign fail      = fail_q;
   assign timed_out = to_q;

   // R8: completion lasts one clock
   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R8: verdict flags only accompany done
   p_quiet_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> (!fail && !timed_out));
   // R2: acceptance closes the request channel
   p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);
   // R7: the busy monitor reports only while the sequencer waits on it
   p_wait_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
      bw_done |-> (state == ST_WAIT));
   // R9: a timeout always fails
   p_timeout_fails_r9: assert property (@(posedge clk) disable iff (!rst_n)
      timed_out |-> fail);

endmodule

// File: tb/nand_erase_seq_test.sv
module nand_erase_seq_test;

   localparam int BLK_W = 14;
   localparam int HALF  = 2;
   localparam int LIMIT = 200;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             req_valid = 1'b0;
   logic             req_ready;
   logic [BLK_W-1:0] req_block = '0;
   logic             done, fail, timed_out;
   logic             nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
   logic [7:0]       nand_dq_out;
   logic [7:0]       nand_dq_in;
   logic             nand_rb = 1'b1;

   int  n_chk = 0;
   int  n_err = 0;
   int  busy_len = 10;
   bit  stat_fail = 1'b0;

   always #10 clk = ~clk;

   nand_erase_seq #(
      .BLK_W(BLK_W), .PG_W(5), .HALF_CYC(HALF), .GUARD_CYC(10),
      .BUSY_LIMIT(LIMIT), .SYNC_STAGES(2)
   ) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_block(req_block), .done(done), .fail(fail), .timed_out(timed_out),
      .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
      .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_out(nand_dq_out),
      .nand_dq_oe(nand_dq_oe), .nand_dq_in(nand_dq_in), .nand_rb(nand_rb)
   );

   // flash device model: status byte with ready bit 6 and fail bit 0
   assign nand_dq_in = {1'b1, 1'b1, 5'b0, stat_fail};

   logic [9:0] log_e [0:511];
   int log_n = 0;
   int rd_n = 0;
   int conf_cnt = 0;

   always @(posedge nand_we_n) begin
      if (rst_n && log_n < 512) begin
         log_e[log_n] = {nand_cle, nand_ale, nand_dq_out};
         log_n = log_n + 1;
         if (nand_cle && nand_dq_out == 8'hD0) conf_cnt = conf_cnt + 1;
      end
   end

   always @(posedge nand_re_n) begin
      if (rst_n) rd_n = rd_n + 1;
   end

   int conf_seen = 0;
   int wb_left = 0;
   int busy_left = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         nand_rb <= 1'b1;
      end else if (conf_cnt != conf_seen) begin
         conf_seen <= conf_cnt;
         wb_left   <= 1;
      end else if (wb_left != 0) begin
         wb_left <= wb_left - 1;
         if (wb_left == 1) begin
            nand_rb   <= 1'b0;
            busy_left <= busy_len;
         end
      end else if (!nand_rb) begin
         if (busy_left <= 1) nand_rb <= 1'b1;
         else busy_left <= busy_left - 1;
      end
   end

   // bus monitors for R6 and R10
   int strobe_low = 0;
   int wmin = 1000;
   int wmax = 0;
   int bad_excl = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (nand_cle && nand_ale) bad_excl = bad_excl + 1;
         if (!nand_we_n && !nand_re_n) bad_excl = bad_excl + 1;
         if (!nand_we_n || !nand_re_n) begin
            strobe_low = strobe_low + 1;
         end else if (strobe_low > 0) begin
            if (strobe_low < wmin) wmin = strobe_low;
            if (strobe_low > wmax) wmax = strobe_low;
            strobe_low = 0;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic run_erase(input int blk, input int blen, input bit sf,
                            input bit exp_to, input bit hold_other);
      int  base  = log_n;
      int  rbase = rd_n;
      int  row   = (blk & 16'h3FFF) * 32;
      int  n_exp = exp_to ? 5 : 6;
      bit  got   = 1'b0;
      busy_len  = blen;
      stat_fail = sf;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1;
      req_block = BLK_W'(blk);
      @(negedge clk);
      chk(!req_ready, "R2 ready low after accept", req_ready, 0);
      if (hold_other) begin
         req_block = BLK_W'(blk) ^ 14'h3FFF;
         for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            chk(!req_ready, "R2 ready stays low while busy", req_ready, 0);
         end
      end
      req_valid = 1'b0;
      for (int w = 0; w < 5000 && !got; w++) begin
         @(negedge clk);
         if (done) got = 1'b1;
      end
      chk(got, "R8 done arrives", got, 1);
      if (got) begin
         chk(fail == (sf | exp_to), "R8 fail verdict", fail, sf | exp_to);
         chk(timed_out == exp_to, "R9 timeout flag", timed_out, exp_to);
         chk(req_ready, "R2 ready back with done", req_ready, 1);
         @(negedge clk);
         chk(!done, "R8 done one clock", done, 0);
      end
      chk(log_n - base == n_exp, "R5 write cycle count", log_n - base, n_exp);
      if (log_n - base == n_exp) begin
         chk(log_e[base] == {2'b10, 8'h60}, "R3 setup command", log_e[base], {2'b10, 8'h60});
         chk(log_e[base+1] == {2'b01, 8'(row)}, "R4 address byte 0",
             log_e[base+1], {2'b01, 8'(row)});
         chk(log_e[base+2] == {2'b01, 8'(row >> 8)}, "R4 address byte 1",
             log_e[base+2], {2'b01, 8'(row >> 8)});
         chk(log_e[base+3] == {2'b01, 8'(row >> 16)}, "R4 address byte 2",
             log_e[base+3], {2'b01, 8'(row >> 16)});
         chk(log_e[base+4] == {2'b10, 8'hD0}, "R5 confirm command",
             log_e[base+4], {2'b10, 8'hD0});
         if (!exp_to)
            chk(log_e[base+5] == {2'b10, 8'h70}, "R7 status command",
                log_e[base+5], {2'b10, 8'h70});
      end
      chk(rd_n - rbase == (exp_to ? 0 : 1), exp_to ? "R9 no status read" : "R7 one status read",
          rd_n - rbase, exp_to ? 0 : 1);
   endtask

   initial begin : main
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(req_ready == 1, "R1 req_ready", req_ready, 1);
      chk(nand_ce_n == 1, "R1 ce_n", nand_ce_n, 1);
      chk(nand_we_n == 1 && nand_re_n == 1, "R1 strobes high", {nand_we_n, nand_re_n}, 3);
      chk(nand_cle == 0 && nand_ale == 0, "R1 latch enables low", {nand_cle, nand_ale}, 0);
      chk(nand_dq_oe == 0, "R1 dq_oe", nand_dq_oe, 0);
      chk(done == 0 && fail == 0 && timed_out == 0, "R1 outputs quiet",
          {done, fail, timed_out}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(req_ready == 1 && nand_we_n == 1, "R1 after reset", {req_ready, nand_we_n}, 3);

      run_erase(0, 20, 1'b0, 1'b0, 1'b0);
      run_erase(16383, 40, 1'b1, 1'b0, 1'b0);
      for (int i = 0; i < BLK_W; i++)
         run_erase(1 << i, 5 + 7 * i, (i % 3) == 0, 1'b0, i == 4);
      run_erase(14'h2AAA, 60, 1'b0, 1'b0, 1'b0);
      run_erase(14'h1555, 1, 1'b1, 1'b0, 1'b0);
      // R9 device stuck busy
      run_erase(77, 2 * LIMIT, 1'b0, 1'b1, 1'b0);
      while (!nand_rb) @(negedge clk);
      repeat (10) @(negedge clk);
      run_erase(12345, 30, 1'b0, 1'b0, 1'b0);

      chk(wmin == HALF && wmax == HALF, "R6 strobe low width", wmax, HALF);
      chk(bad_excl == 0, "R10 exclusive enables", bad_excl, 0);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule